// File: doc/BRIEF.md
# Two-Stage SPI Baud Divider

This block turns the module clock into a stream of one-cycle edge ticks for an SPI shifter. The shifter flips its serial clock on every tick. Two 3-bit configuration fields set the rate. A linear prescale field `pre_sel` (value P) and an exponent field `pow_sel` (value S) give a module-clock divisor of (P+1)·2^(S+1) per serial clock period. Ticks therefore come every half period H = (P+1)·2^S module clocks.

Inside, a mod-(P+1) counter feeds a binary counter that wraps after 2^S prescaler steps. Both counters are cleared while the enable is low. They are also cleared in any cycle where the configuration differs from the value held one cycle earlier. This means every rate change starts from a clean phase, and the first tick after a restart comes a full half period later. A registered reference output `sck_ref` toggles on each tick. It gives a 50% duty clock at the serial rate that starts low.

Top module: `baud_div`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `edge_tick` and `sck_ref` are 0.
- R2: With enable high and a stable configuration, `edge_tick` pulses exactly once every H = (P+1)·2^S module clocks, where P = `pre_sel` and S = `pow_sel` read as unsigned numbers.
- R3: With `pre_sel`=0 and `pow_sel`=0 (divisor 2), `edge_tick` is high on every clock while enabled.
- R4: With `pre_sel`=0, `pow_sel`=1 gives a tick every 2 clocks (divisor 4), and `pow_sel`=2 gives one every 4 clocks (divisor 8).
- R5: With `pre_sel`=7 and `pow_sel`=7 (divisor 2048), ticks are 1024 clocks apart.
- R6: When `en` is sampled high for the first time after being low, with the configuration stable, the first `edge_tick` appears H clock edges later, counting that edge as the first.
- R7: One clock after `en` is sampled low, `edge_tick` and `sck_ref` are 0, and they stay 0 while `en` stays low, even if the configuration changes.
- R8: When the configuration changes while enabled, both outputs are 0 after the next edge, and the first tick under the new setting comes H_new edges after that.
- R9: `sck_ref` starts at 0 after any restart, inverts on the same edge that raises `edge_tick`, and holds its value otherwise. Its period is 2H with 50% duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Divider enable; low holds and clears the divider |
| pre_sel | input | 3 | Linear prescale field P, factor P+1 |
| pow_sel | input | 3 | Exponent field S, factor 2^(S+1) |
| edge_tick | output | 1 | One-cycle tick every half serial-clock period |
| sck_ref | output | 1 | Serial-rate reference clock, toggles on each tick |

## Verification
The hardest situation to create is a configuration change in the middle of a half period while enabled. The restart has to throw away a partly counted phase and re-anchor the tick train exactly one edge later. The bench reaches it by ending a running window at an arbitrary cycle and loading a new setting on that same negative edge while enable stays high. It then checks the full tick and reference pattern against a timeline shifted by one clock. The largest setting is also run in full, so the widest counter wraps are exercised.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;

    localparam int PRE_W = 3;
    localparam int POW_W = 3;
    localparam int POW_N = 1 << POW_W;
    localparam int BC_W  = POW_N - 1;
    localparam int HP_W  = PRE_W + POW_N;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [POW_W-1:0] pow;
    } baud_cfg_t;

    // Half serial-clock period in module clocks: (P+1) * 2^S
    function automatic logic [HP_W-1:0] half_period(baud_cfg_t c);
        logic [HP_W-1:0] base;
        base = HP_W'(c.pre) + HP_W'(1);
        return base << c.pow;
    endfunction

    // Terminal count of the binary stage: 2^S - 1
    function automatic logic [BC_W-1:0] pow_limit(logic [POW_W-1:0] s);
        logic [BC_W:0] one_hot;
        one_hot = (BC_W+1)'(1) << s;
        return BC_W'(one_hot - (BC_W+1)'(1));
    endfunction

endpackage

// File: rtl/baud_cfg_watch.sv
module baud_cfg_watch
    import baud_div_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  baud_cfg_t cfg_i,
    output baud_cfg_t cfg_q_o,
    output logic      clr_o
);

    baud_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_i;
    end

    assign clr_o   = !en || (cfg_i != cfg_q);
    assign cfg_q_o = cfg_q;

endmodule

// File: rtl/baud_prescale.sv
module baud_prescale
    import baud_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [PRE_W-1:0] pre_lim,
    output logic             pre_tick
);

    logic [PRE_W-1:0] pc;

    always_ff @(posedge clk) begin
        if (rst || clr)          pc <= '0;
        else if (pc == pre_lim)  pc <= '0;
        else                     pc <= pc + PRE_W'(1);
    end

    assign pre_tick = !clr && (pc == pre_lim);

    p_pc_bound_r2: assert property (@(posedge clk) disable iff (rst)
        !clr |-> pc <= pre_lim);

    p_pc_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> pc == '0);

endmodule

// File: rtl/baud_pow2.sv
module baud_pow2
    import baud_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic [POW_W-1:0] pow_sel,
    output logic             tick
);

    logic [BC_W-1:0] bc;
    logic [BC_W-1:0] lim;

    assign lim  = pow_limit(pow_sel);
    assign tick = step && (bc == lim);

    always_ff @(posedge clk) begin
        if (rst || clr)  bc <= '0;
        else if (step)   bc <= (bc == lim) ? '0 : bc + BC_W'(1);
    end

    p_bc_bound_r2: assert property (@(posedge clk) disable iff (rst)
        !clr |-> bc <= lim);

    p_bc_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> bc == '0);

endmodule

// File: rtl/baud_div.sv
module baud_div
    import baud_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PRE_W-1:0] pre_sel,
    input  logic [POW_W-1:0] pow_sel,
    output logic             edge_tick,
    output logic             sck_ref
);

    baud_cfg_t cfg, cfg_prev;
    logic      clr, pre_tick, tick;
    logic      tick_q, sck_q;

    assign cfg.pre = pre_sel;
    assign cfg.pow = pow_sel;

    baud_cfg_watch u_watch (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .cfg_i   (cfg),
        .cfg_q_o (cfg_prev),
        .clr_o   (clr)
    );

    baud_prescale u_pre (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .pre_lim  (pre_sel),
        .pre_tick (pre_tick)
    );

    baud_pow2 u_pow (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .step    (pre_tick),
        .pow_sel (pow_sel),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tick_q <= 1'b0;
            sck_q  <= 1'b0;
        end else begin
            tick_q <= tick;
            if (tick) sck_q <= ~sck_q;
        end
    end

    assign edge_tick = tick_q;
    assign sck_ref   = sck_q;

    // Checker: clocks elapsed since the last tick or restart
    logic [HP_W:0] gap_cnt;
    always_ff @(posedge clk) begin
        if (rst || clr)              gap_cnt <= '0;
        else if (tick_q)             gap_cnt <= (HP_W+1)'(1);
        else if (gap_cnt != '1)      gap_cnt <= gap_cnt + (HP_W+1)'(1);
    end

    p_gap_r2: assert property (@(posedge clk) disable iff (rst)
        edge_tick |-> gap_cnt == {1'b0, half_period(cfg_prev)});

    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> (!edge_tick && !sck_ref));

    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> (!edge_tick && !sck_ref));

    p_sck_toggle_r9: assert property (@(posedge clk) disable iff (rst)
        edge_tick |-> sck_ref != $past(sck_ref));

    p_sck_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!edge_tick && !$past(clr)) |-> $stable(sck_ref));

endmodule

// File: tb/tb_baud_div.sv
module tb_baud_div;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [2:0] pre_sel = '0;
    logic [2:0] pow_sel = '0;
    logic       edge_tick, sck_ref;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_div dut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .pre_sel   (pre_sel),
        .pow_sel   (pow_sel),
        .edge_tick (edge_tick),
        .sck_ref   (sck_ref)
    );

    function automatic int exp_half(int p, int s);
        return (p + 1) * (1 << s);
    endfunction

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Samples n cycles; ticks are expected at k = offset + m*h
    task automatic run_window(input int offset, input int h, input int n, input string tag);
        int bad_t = 0, bad_s = 0;
        int at_k = 0, at_act = 0, at_exp = 0;
        int as_k = 0, as_act = 0, as_exp = 0;
        for (int k = 1; k <= n; k++) begin
            int et, es;
            @(negedge clk);
            et = (k > offset && ((k - offset) % h) == 0) ? 1 : 0;
            es = (k > offset) ? (((k - offset) / h) % 2) : 0;
            if (int'(edge_tick) != et && bad_t == 0) begin
                bad_t = 1; at_k = k; at_act = int'(edge_tick); at_exp = et;
            end
            if (int'(sck_ref) != es && bad_s == 0) begin
                bad_s = 1; as_k = k; as_act = int'(sck_ref); as_exp = es;
            end
        end
        if (bad_t != 0) $display("  tick mismatch at cycle %0d (H=%0d)", at_k, h);
        check(tag, bad_t == 0, at_act, at_exp);
        if (bad_s != 0) $display("  sck_ref mismatch at cycle %0d (H=%0d)", as_k, h);
        check("R9", bad_s == 0, as_act, as_exp);
    endtask

    task automatic start_cfg(input int p, input int s);
        @(negedge clk);
        en = 1'b0;
        pre_sel = 3'(p);
        pow_sel = 3'(s);
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1", edge_tick == 1'b0 && sck_ref == 1'b0, int'({edge_tick, sck_ref}), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", edge_tick == 1'b0 && sck_ref == 1'b0, int'({edge_tick, sck_ref}), 0);

        // R3: divide by 2
        start_cfg(0, 0);
        run_window(0, 1, 12, "R3");
        // R4: divide by 4 and by 8
        start_cfg(0, 1);
        run_window(0, 2, 12, "R4");
        start_cfg(0, 2);
        run_window(0, 4, 20, "R4");
        // R2: linear stage alone and mixed
        start_cfg(2, 0);
        run_window(0, 3, 20, "R2");
        start_cfg(4, 3);
        run_window(0, 40, 130, "R2");
        // R6: first tick exactly H after enable
        start_cfg(5, 1);
        run_window(0, 12, 13, "R6");
        // R5: largest setting
        start_cfg(7, 7);
        run_window(0, 1024, 2 * 1024 + 3, "R5");

        // R8: change configuration mid-period while enabled
        start_cfg(3, 2);
        run_window(0, 16, 23, "R2");
        pre_sel = 3'd1; pow_sel = 3'd1;
        run_window(1, 4, 30, "R8");
        pre_sel = 3'd6; pow_sel = 3'd0;
        run_window(1, 7, 30, "R8");

        // R7: disable clears and holds outputs low
        begin
            int bad = 0;
            en = 1'b0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (k == 4) begin pre_sel = 3'd0; pow_sel = 3'd0; end
                if (edge_tick || sck_ref) bad++;
            end
            check("R7", bad == 0, bad, 0);
        end

        // R2 / R6 / R9: randomized settings
        for (int i = 0; i < 20; i++) begin
            int p, s, h;
            p = int'($urandom_range(0, 7));
            s = int'($urandom_range(0, 5));
            h = exp_half(p, s);
            start_cfg(p, s);
            run_window(0, h, 3 * h + 2, "R2");
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule